// File: doc/BRIEF.md
# LAPD Message Frame Transmitter

This block sends one data-link frame that carries a stored maintenance message when a processor command starts it. The message bytes sit in an external transmit buffer. The block reads them through an address/data port and puts three fixed header octets in front of them. Those octets are two address octets (service point identifier, command/response bit, extension bits) and one control octet. After the message it appends a 16-bit frame check sequence. The frame is bracketed by flag octets and its contents are zero-stuffed. The result leaves as a serial bit stream. That stream feeds a data-link bit slot in the outgoing line frames, and it advances one bit each time the slot-enable strobe is high.

Software uses a single 8-bit control/status register. A write with the start bit set launches a frame. A busy flag shows that the frame is in flight. A status bit records completion and is cleared when the register is read. An enable bit routes that status to an interrupt output. Outside a frame the line carries continuous idle flags.

Top module: `lapd_frame_tx`

## Requirements
- R1: A register write with bit 0 (start) set while busy is 0 sets busy (bit 2) in the next cycle and causes exactly one frame to be sent.
- R2: The frame contents are sent least significant bit first, in this order:
  - header octet `{SAPI, CR, 0}` (0x3A by default);
  - header octet `{TEI, 1}` (0x01 by default);
  - control octet 0x03;
  - the message bytes from buffer addresses 0 to length-1, in address order;
  - the two check octets.
- R3: The check value is CRC-16 with polynomial x^16+x^12+x^5+1 and a preset of 0xFFFF. It is computed over the header and message bits in transmit order. Its ones-complement is sent least significant bit first, so the low octet goes first.
- R4: Between the flags, a 0 is inserted after every five consecutive 1s. Flags (0x7E) are never stuffed. Idle flags are sent continuously whenever no frame is active, so no run of consecutive 1s on the line exceeds six.
- R5: The serial output advances by exactly one bit on each clock edge where `dl_en` is 1, and it holds its value while `dl_en` is 0.
- R6: Busy returns to 0 on the edge that consumes the last bit of the closing flag. On that same edge the done status (bit 3) is set to 1.
- R7: A register read clears the done status, so it reads 1 only if a frame completed since the previous read. A completion on the same edge as the read takes priority over the clear.
- R8: `irq` equals done status AND interrupt enable. The enable is bit 1 and is written on every register write.
- R9: All register bits reset to 0. Bits 7 to 4 always read 0, and the start bit reads 0.
- R10: A start written while busy is 1 is ignored. The message length is latched at the accepted start, so later changes to `msg_len` do not affect the frame in flight.
- R11: Message lengths from 0 to 127 bytes are sent correctly. A length of 0 gives a frame made of the header and the check octets only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears done status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data `{0000, done, busy, ie, 0}` |
| irq | output | 1 | Transmission-complete interrupt |
| buf_addr | output | ADDR_W | Message buffer read address |
| buf_data | input | 8 | Message buffer read data (same-cycle) |
| msg_len | input | ADDR_W | Message length in bytes, latched at start |
| dl_en | input | 1 | Data-link bit slot strobe |
| dl_bit | output | 1 | Serial data-link output |

## Verification
Several message patterns are sent through a bench-side receiver that finds flags and removes stuffing:
- Incrementing bytes show that the header and message octets come out in order and with the right bit order.
- All-ones bytes force a stuffed zero after every fifth bit. They separate correct stuffing from dropped or misplaced stuff bits, and they give a check-octet pattern where five 1s can run up to the closing flag.
- Empty and maximum-length messages cover the byte-counter limits.

A sparse slot strobe shows that the stream stalls rather than skips. A second start mid-frame, combined with a changed length input, separates an ignored command from a restarted or lengthened frame.

// File: rtl/lapd_frame_tx.sv
module lapd_frame_tx #(
  parameter int          ADDR_W = 7,
  parameter logic [5:0]  SAPI   = 6'd14,
  parameter logic        CR     = 1'b1,
  parameter logic [6:0]  TEI    = 7'd0,
  parameter logic [7:0]  CTRL   = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic [7:0]        buf_data,
  input  logic [ADDR_W-1:0] msg_len,
  input  logic              dl_en,
  output logic              dl_bit
);
  localparam int         IW   = ADDR_W + 1;
  localparam logic [7:0] FLAG = 8'h7E;
  localparam logic [7:0] HDR0 = {SAPI, CR, 1'b0};
  localparam logic [7:0] HDR1 = {TEI, 1'b1};
  localparam logic [15:0] POLY_R = 16'h8408;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_FCS, S_CLOSE} ph_t;

  ph_t              ph;
  logic [3:0]       cnt;
  logic [IW-1:0]    idx;
  logic [2:0]       ones;
  logic [15:0]      crc;
  logic [ADDR_W-1:0] len_q;
  logic             busy, ie, done_sts;
  logic             raw, stuff;
  logic [7:0]       cur_byte;

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata[7:2];

  assign cur_byte = (idx == IW'(0)) ? HDR0 :
                    (idx == IW'(1)) ? HDR1 :
                    (idx == IW'(2)) ? CTRL : buf_data;
  assign buf_addr = (idx < IW'(3)) ? '0 : ADDR_W'(idx - IW'(3));

  always_comb begin
    case (ph)
      S_DATA:  raw = cur_byte[cnt[2:0]];
      S_FCS:   raw = ~crc[cnt];
      default: raw = FLAG[cnt[2:0]];
    endcase
  end

  assign stuff     = (ph != S_IDLE) && (ones == 3'd5);
  assign dl_bit    = stuff ? 1'b0 : raw;
  assign reg_rdata = {4'b0000, done_sts, busy, ie, 1'b0};
  assign irq       = done_sts & ie;

  wire last_data = (idx == IW'(len_q) + IW'(2));
  wire start_ok  = reg_wr && reg_wdata[0] && !busy;
  wire finish    = dl_en && !stuff && (ph == S_CLOSE) && (cnt[2:0] == 3'd7);
  wire [15:0] crc_nx = {1'b0, crc[15:1]} ^ ((crc[0] ^ raw) ? POLY_R : 16'h0000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= S_IDLE;
      cnt      <= '0;
      idx      <= '0;
      ones     <= '0;
      crc      <= 16'hFFFF;
      len_q    <= '0;
      busy     <= 1'b0;
      ie       <= 1'b0;
      done_sts <= 1'b0;
    end else begin
      if (reg_wr) ie <= reg_wdata[1];
      if (start_ok) begin
        busy  <= 1'b1;
        len_q <= msg_len;
      end
      if (finish) begin
        busy     <= 1'b0;
        done_sts <= 1'b1;
      end else if (reg_rd) begin
        done_sts <= 1'b0;
      end

      if (dl_en) begin
        if (stuff) begin
          ones <= '0;
        end else begin
          if (ph == S_DATA || ph == S_FCS) ones <= raw ? ones + 3'd1 : 3'd0;
          if (ph == S_DATA) crc <= crc_nx;
          case (ph)
            S_IDLE: begin
              if (cnt[2:0] == 3'd7) begin
                cnt <= '0;
                if (busy) begin
                  ph   <= S_DATA;
                  idx  <= '0;
                  crc  <= 16'hFFFF;
                  ones <= '0;
                end
              end else cnt <= cnt + 4'd1;
            end
            S_DATA: begin
              if (cnt[2:0] == 3'd7) begin
                cnt <= '0;
                if (last_data) ph <= S_FCS;
                else           idx <= idx + IW'(1);
              end else cnt <= cnt + 4'd1;
            end
            S_FCS: begin
              if (cnt == 4'd15) begin
                cnt <= '0;
                ph  <= S_CLOSE;
              end else cnt <= cnt + 4'd1;
            end
            default: begin
              if (cnt[2:0] == 3'd7) begin
                cnt <= '0;
                ph  <= S_IDLE;
              end else cnt <= cnt + 4'd1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/lapd_frame_tx_chk.sv
module lapd_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       irq,
  input logic [7:0] buf_data,
  input logic       dl_en,
  input logic       dl_bit
);
  logic [3:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (dl_en) run <= dl_bit ? ((run == 4'd15) ? run : run + 4'd1) : 4'd0;
  end

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_wdata[0] && !reg_rdata[2] |=> reg_rdata[2]);

  p_busy_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[2]) |-> $past(reg_wr && reg_wdata[0]));

  p_run_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dl_en && dl_bit |-> run < 4'd6);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dl_en |=> $stable(dl_bit) || !$stable(buf_data));

  p_done_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[2]) |-> reg_rdata[3]);

  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !reg_rdata[2] |=> !reg_rdata[3]);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> reg_rdata[1] && reg_rdata[3]);

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:4] == 4'b0000 && !reg_rdata[0]);
endmodule

bind lapd_frame_tx lapd_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
  .buf_data(buf_data), .dl_en(dl_en), .dl_bit(dl_bit)
);

// File: tb/sim_lapd_frame_tx.sv
module sim_lapd_frame_tx;
  localparam int CLK_NS = 10;
  localparam int AW = 7;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic irq;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_data;
  logic [AW-1:0] msg_len = 0;
  logic dl_en = 0;
  logic dl_bit;

  logic [7:0] mem [0:127];
  assign buf_data = mem[buf_addr];

  lapd_frame_tx u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .buf_addr(buf_addr),
    .buf_data(buf_data), .msg_len(msg_len), .dl_en(dl_en), .dl_bit(dl_bit));

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, errors = 0;
  int en_period = 1, en_cnt = 0;
  int ones_rx = 0, nb = 0, frames = 0, frm_len = 0, run = 0, maxrun = 0;
  int stall_err = 0;
  bit rxb [0:4095];
  logic [7:0] frm [0:255];
  logic prev_en = 0, prev_bit = 0;
  bit ie_sh = 0;
  int cyc = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rx_bit(bit b);
    run = b ? run + 1 : 0;
    if (run > maxrun) maxrun = run;
    if (b == 0 && ones_rx == 5) begin
    end else if (b == 1 && ones_rx >= 5) begin
    end else if (b == 0 && ones_rx >= 6) begin
      int n = nb - 6;
      if (n > 0) begin
        frm_len = (n % 8 == 0) ? n / 8 : -1;
        for (int k = 0; k < n / 8 && k < 256; k++)
          for (int j = 0; j < 8; j++) frm[k][j] = rxb[k*8 + j];
        frames++;
      end
      nb = 0;
    end else if (nb < 4096) begin
      rxb[nb] = b;
      nb++;
    end
    ones_rx = b ? ones_rx + 1 : 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && prev_en == 0 && dl_bit !== prev_bit) stall_err++;
    en_cnt++;
    dl_en = rst_n && ((en_cnt % en_period) == 0);
    if (dl_en) rx_bit(dl_bit);
    prev_en = dl_en;
    prev_bit = dl_bit;
  end

  task automatic wr(logic [7:0] v);
    @(negedge clk);
    reg_wr = 1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk);
    reg_rd = 1; v = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic wait_idle(string tag);
    int t = 0;
    while (reg_rdata[2] && t < 40000) begin @(negedge clk); t++; end
    chk(t < 40000, tag, t, 0);
  endtask

  task automatic check_frame(int L, string tag);
    logic [7:0] e [0:255];
    logic [15:0] c = 16'hFFFF;
    int bad = 0;
    e[0] = 8'h3A; e[1] = 8'h01; e[2] = 8'h03;
    for (int k = 0; k < L; k++) e[3+k] = mem[k];
    for (int k = 0; k < L + 3; k++)
      for (int j = 0; j < 8; j++) begin
        bit fb = c[0] ^ e[k][j];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    c = ~c;
    e[L+3] = c[7:0]; e[L+4] = c[15:8];
    chk(frm_len == L + 5, {tag, " R2 length"}, frm_len, L + 5);
    for (int k = 0; k < L + 3; k++) if (frm[k] !== e[k]) bad++;
    chk(bad == 0, {tag, " R2 octets"}, bad, 0);
    chk({frm[L+4], frm[L+3]} == c, {tag, " R3 fcs"}, {frm[L+4], frm[L+3]}, c);
  endtask

  task automatic send(int L, int kind, int period, bit ie, string tag);
    logic [7:0] v;
    int f0;
    for (int k = 0; k < 128; k++)
      mem[k] = (kind == 0) ? 8'(k * 7 + 1) : (kind == 1) ? 8'hFF : 8'(k ^ 8'hA5);
    en_period = period;
    ie_sh = ie;
    msg_len = AW'(L);
    f0 = frames;
    wr({6'd0, ie, 1'b1});
    chk(reg_rdata[2] == 1'b1, {tag, " R1 busy after start"}, reg_rdata[2], 1);
    chk(reg_rdata[0] == 1'b0, {tag, " R9 start reads 0"}, reg_rdata[0], 0);
    wait_idle({tag, " R6 busy clears"});
    chk(frames == f0 + 1, {tag, " R1 one frame"}, frames - f0, 1);
    check_frame(L, tag);
    chk(reg_rdata[3] == 1'b1, {tag, " R6 done set"}, reg_rdata[3], 1);
    chk(irq == ie, {tag, " R8 irq gate"}, irq, ie);
    if (ie) begin
      rd(v);
      chk(v[3] == 1'b1, {tag, " R7 first read"}, v[3], 1);
      rd(v);
      chk(v[3] == 1'b0, {tag, " R7 second read"}, v[3], 0);
      chk(irq == 1'b0, {tag, " R8 irq after read"}, irq, 0);
    end
  endtask

  task automatic t_reset();
    repeat (300) @(negedge clk);
    chk(reg_rdata == 8'h00, "R9 reset value", reg_rdata, 0);
    chk(irq == 1'b0, "R8 reset irq", irq, 0);
    chk(frames == 0, "R4 idle has no frame", frames, 0);
    chk(maxrun == 6, "R4 idle flags", maxrun, 6);
  endtask

  task automatic t_disabled_irq();
    logic [7:0] v;
    send(3, 2, 1, 1'b0, "noirq");
    wr(8'h02);
    chk(irq == 1'b1, "R8 enable after done", irq, 1);
    rd(v);
    chk(irq == 1'b0, "R7 clear drops irq", irq, 0);
  endtask

  task automatic t_busy_ignore();
    int f0 = frames;
    for (int k = 0; k < 128; k++) mem[k] = 8'(k + 3);
    en_period = 1;
    msg_len = AW'(20);
    wr(8'h03);
    repeat (40) @(negedge clk);
    msg_len = AW'(2);
    wr(8'h03);
    wait_idle("R10 busy clears");
    chk(frames == f0 + 1, "R10 single frame", frames - f0, 1);
    check_frame(20, "R10");
    repeat (300) @(negedge clk);
    chk(frames == f0 + 1, "R10 no second frame", frames - f0, 1);
    chk(reg_rdata[2] == 1'b0, "R10 stays idle", reg_rdata[2], 0);
  endtask

  task automatic t_unused();
    logic [7:0] v;
    rd(v);
    wr(8'hFC);
    chk(reg_rdata == 8'h00, "R9 upper bits read 0", reg_rdata, 0);
    wr(8'hF2);
    chk(reg_rdata == 8'h02, "R9 ie only", reg_rdata, 2);
    wr(8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    send(5, 0, 1, 1'b1, "inc");
    send(16, 1, 1, 1'b1, "R4 ones");
    chk(maxrun <= 6, "R4 max run", maxrun, 6);
    send(0, 0, 1, 1'b1, "R11 empty");
    send(127, 2, 1, 1'b1, "R11 max");
    send(9, 0, 3, 1'b1, "R5 sparse");
    chk(stall_err == 0, "R5 hold while stalled", stall_err, 0);
    t_disabled_irq();
    t_busy_ignore();
    t_unused();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule